// File: doc/BRIEF.md
# Overlapping Two-Section Frame Splitter and Merger

This block lets two identical 3x3 neighbourhood pipelines work on one raster frame at once. The incoming pixel stream is routed onto two lanes. The upper lane receives the top half of the frame plus four rows below the midline. The lower lane receives the bottom half plus four rows above the midline. Rows inside the eight-row band around the midline go to both lanes on the same clock. Each pipeline therefore sees complete neighbourhoods at the seam, even when two 3x3 stages are cascaded. Each lane carries its own start-of-section and end-of-line markers, so a downstream pipeline can restart its line buffers at the first row of its section.

The processed lanes return to the block. The merge side counts rows on each returning lane. It forwards the first half-height rows of the upper lane and discards that lane's four trailing rows. It discards the four leading rows of the lower lane and buffers the rest in a small FIFO. The FIFO is drained once the upper lane's last useful row has been emitted. The merged stream therefore has exactly the full frame in raster order. Frame width, frame height, pixel width, seam depth and FIFO depth are parameters. The height must be even and at least 8.

Top module: `frame_seam_split`

## Requirements
- R1: The upper lane carries frame rows 0 to H/2+3 (H is the frame height), in input order, one clock after each accepted input pixel.
- R2: The lower lane carries frame rows H/2-4 to H-1, in input order, one clock after each accepted input pixel.
- R3: Every pixel of rows H/2-4 to H/2+3 appears on both lanes in the same cycle with identical data, and no other row appears on both lanes.
- R4: Lane markers: up_sos is high only with the first pixel of frame row 0, and dn_sos is high only with the first pixel of frame row H/2-4. Each lane raises its eol with the last pixel of every row it carries. An input pixel with in_eol high is the last of a row of W pixels.
- R5: Input cycles with in_valid low have no effect, whatever in_sof, in_eol and in_data carry: no lane or merged output becomes valid, and no row or column position advances.
- R6: On the merged output, exactly H/2 rows come from the returning upper lane (section rows 0 to H/2-1), and that lane's last four section rows are discarded.
- R7: The returning lower lane's first four section rows are discarded. Its remaining H/2 rows are emitted after the last upper-lane row. The merged stream equals the frame in raster order, with out_sof only on the first pixel and out_eol on each row's last pixel.
- R8: While rst_n is low at a clock edge, all valid and marker outputs go low and all row and phase state restarts. A frame sent after a reset that interrupted an earlier frame is split and merged correctly.
- R9: When the lower lane returns its rows ahead of the upper lane by up to FIFO_DEPTH pixels, the merge buffering holds them with no loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input pixel present |
| in_sof | input | 1 | Input pixel is the first of a frame |
| in_eol | input | 1 | Input pixel is the last of a row |
| in_data | input | DW | Input pixel value |
| up_valid | output | 1 | Upper lane pixel present |
| up_sos | output | 1 | Upper lane start of section |
| up_eol | output | 1 | Upper lane end of row |
| up_data | output | DW | Upper lane pixel |
| dn_valid | output | 1 | Lower lane pixel present |
| dn_sos | output | 1 | Lower lane start of section |
| dn_eol | output | 1 | Lower lane end of row |
| dn_data | output | DW | Lower lane pixel |
| ru_valid | input | 1 | Returning upper lane pixel present |
| ru_sos | input | 1 | Returning upper lane start of section |
| ru_eol | input | 1 | Returning upper lane end of row |
| ru_data | input | DW | Returning upper lane pixel |
| rd_valid | input | 1 | Returning lower lane pixel present |
| rd_sos | input | 1 | Returning lower lane start of section |
| rd_eol | input | 1 | Returning lower lane end of row |
| rd_data | input | DW | Returning lower lane pixel |
| out_valid | output | 1 | Merged pixel present |
| out_sof | output | 1 | Merged first pixel of frame |
| out_eol | output | 1 | Merged end of row |
| out_data | output | DW | Merged pixel |

## Verification
Frames are sent as a position ramp, a constant, a checkerboard and seeded hash images. A ramp that is split or merged at a wrong row shows up as misplaced values. A constant frame exposes only count and marker errors. A checkerboard or hash catches rows that were swapped or duplicated. The frames are sent back-to-back or with idle cycles whose sof, eol and data carry junk, which separates pixel-driven counting from marker-driven counting. The returning lanes use unequal delays, with the lower lane faster, so the merge has to buffer the lower half. A reset in the middle of a frame checks that row state restarts cleanly.

// File: rtl/seam_pkg.sv
// Package: shared types for the overlapping frame splitter.
// Assumes nothing beyond IEEE 1800-2017 packages.
package seam_pkg;

    // Merge phase: forwarding the upper lane, or draining the lower lane buffer.
    typedef enum logic {
        PH_UPPER = 1'b0,
        PH_LOWER = 1'b1
    } merge_phase_t;

endpackage

// File: rtl/seam_fifo.sv
// Module: seam_fifo
// Single-clock FIFO with a combinational head read. It holds lower-lane pixels
// while the upper lane finishes. Assumes DEPTH is a power of two and at least 2,
// and that the writer never pushes into a full FIFO unless it pops in the same cycle.
module seam_fifo #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             empty,
    output logic             full
);
    localparam int PW = $clog2(DEPTH);
    localparam logic [PW:0] FULL_CNT = (PW+1)'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wr_ptr;
    logic [PW-1:0]    rd_ptr;
    logic [PW:0]      count;

    assign rdata = mem[rd_ptr];
    assign empty = (count == '0);
    assign full  = (count == FULL_CNT);

    // Storage write on push.
    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= wdata;
        end
    end

    // Pointer and occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= rd_ptr + 1'b1;
            end
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R9: buffering never loses a pixel.
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |-> pop);

    // R9: the head is never consumed from an empty buffer.
    p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count != '0));

endmodule

// File: rtl/seam_splitter.sv
// Module: seam_splitter
// Routes an input raster onto an upper and a lower lane. The sections overlap by
// SEAM rows on each side of the midline. Tracks row and column from in_sof and
// in_eol and counts only valid pixels. Assumes H even, H >= 2*SEAM, and W >= 2.
module seam_splitter #(
    parameter int W    = 8,
    parameter int H    = 16,
    parameter int DW   = 8,
    parameter int SEAM = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_sof,
    input  logic          in_eol,
    input  logic [DW-1:0] in_data,
    output logic          up_valid,
    output logic          up_sos,
    output logic          up_eol,
    output logic [DW-1:0] up_data,
    output logic          dn_valid,
    output logic          dn_sos,
    output logic          dn_eol,
    output logic [DW-1:0] dn_data
);
    localparam int HALF = H / 2;
    localparam int RW   = $clog2(H);
    localparam int CW   = $clog2(W);
    localparam logic [RW-1:0] UP_LAST  = RW'(HALF + SEAM - 1);
    localparam logic [RW-1:0] DN_FIRST = RW'(HALF - SEAM);
    localparam logic [RW-1:0] ROW_LAST = RW'(H - 1);
    localparam logic [CW-1:0] COL_LAST = CW'(W - 1);

    logic [RW-1:0] row_q;
    logic [CW-1:0] col_q;
    logic [RW-1:0] cur_row;
    logic [CW-1:0] cur_col;
    logic          to_up;
    logic          to_dn;

    // Position of the current input pixel; in_sof restarts the frame.
    always_comb begin
        cur_row = in_sof ? '0 : row_q;
        cur_col = in_sof ? '0 : col_q;
        to_up   = in_valid && (cur_row <= UP_LAST);
        to_dn   = in_valid && (cur_row >= DN_FIRST);
    end

    // Row and column counters advance only on valid pixels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
            col_q <= '0;
        end else if (in_valid) begin
            if (in_eol) begin
                col_q <= '0;
                row_q <= (cur_row == ROW_LAST) ? '0 : cur_row + 1'b1;
            end else begin
                col_q <= cur_col + 1'b1;
                row_q <= cur_row;
            end
        end
    end

    // Upper lane register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up_valid <= 1'b0;
            up_sos   <= 1'b0;
            up_eol   <= 1'b0;
            up_data  <= '0;
        end else begin
            up_valid <= to_up;
            up_sos   <= to_up && (cur_row == '0) && (cur_col == '0);
            up_eol   <= to_up && in_eol;
            if (to_up) begin
                up_data <= in_data;
            end
        end
    end

    // Lower lane register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dn_valid <= 1'b0;
            dn_sos   <= 1'b0;
            dn_eol   <= 1'b0;
            dn_data  <= '0;
        end else begin
            dn_valid <= to_dn;
            dn_sos   <= to_dn && (cur_row == DN_FIRST) && (cur_col == '0);
            dn_eol   <= to_dn && in_eol;
            if (to_dn) begin
                dn_data <= in_data;
            end
        end
    end

    // R4: an end-of-line pixel closes a row of exactly W pixels.
    p_eol_at_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_eol) |-> (cur_col == COL_LAST));

    // R5: no lane emits a pixel unless a valid input was taken one cycle earlier.
    p_lane_needs_input_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid || dn_valid) |-> $past(in_valid));

    // R1 R2: every accepted pixel reaches at least one lane.
    p_pixel_routed_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid)) |-> (up_valid || dn_valid));

    // R4: the two sections never start on the same pixel.
    p_sos_distinct_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(up_sos && dn_sos));

endmodule

// File: rtl/seam_merger.sv
// Module: seam_merger
// Rebuilds a raster frame from the two returning lanes. It keeps the first H/2
// rows of the upper lane, skips the first SEAM rows of the lower lane, and
// buffers the lower rows until the upper half is out. Assumes each returning
// lane keeps its section's row order and markers, and that the next frame's
// upper rows do not arrive before the lower rows of the previous frame have drained.
module seam_merger #(
    parameter int W          = 8,
    parameter int H          = 16,
    parameter int DW         = 8,
    parameter int SEAM       = 4,
    parameter int FIFO_DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ru_valid,
    input  logic          ru_sos,
    input  logic          ru_eol,
    input  logic [DW-1:0] ru_data,
    input  logic          rd_valid,
    input  logic          rd_sos,
    input  logic          rd_eol,
    input  logic [DW-1:0] rd_data,
    output logic          out_valid,
    output logic          out_sof,
    output logic          out_eol,
    output logic [DW-1:0] out_data
);
    import seam_pkg::*;

    localparam int HALF = H / 2;
    localparam int SW   = $clog2(H + 1);
    localparam logic [SW-1:0] KEEP_ROWS = SW'(HALF);
    localparam logic [SW-1:0] KEEP_LAST = SW'(HALF - 1);
    localparam logic [SW-1:0] SKIP_ROWS = SW'(SEAM);

    merge_phase_t  phase_q;
    logic [SW-1:0] u_row_q;
    logic [SW-1:0] d_row_q;
    logic [SW-1:0] drain_row_q;
    logic [SW-1:0] u_cur;
    logic [SW-1:0] d_cur;
    logic          u_keep;
    logic          d_keep;
    logic          pop;
    logic          f_empty;
    logic          f_full;
    logic [DW:0]   f_head;

    // Section-local row of each returning pixel and the keep decision.
    always_comb begin
        u_cur  = ru_sos ? '0 : u_row_q;
        d_cur  = rd_sos ? '0 : d_row_q;
        u_keep = ru_valid && (u_cur < KEEP_ROWS);
        d_keep = rd_valid && (d_cur >= SKIP_ROWS);
        pop    = (phase_q == PH_LOWER) && !f_empty;
    end

    // Returning-lane row counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            u_row_q <= '0;
            d_row_q <= '0;
        end else begin
            if (ru_valid) begin
                u_row_q <= ru_eol ? u_cur + 1'b1 : u_cur;
            end
            if (rd_valid) begin
                d_row_q <= rd_eol ? d_cur + 1'b1 : d_cur;
            end
        end
    end

    // Phase: switch to draining after the last useful upper row, back when H/2 lower rows are out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q     <= PH_UPPER;
            drain_row_q <= '0;
        end else if (phase_q == PH_UPPER) begin
            if (u_keep && ru_eol && (u_cur == KEEP_LAST)) begin
                phase_q <= PH_LOWER;
            end
            drain_row_q <= '0;
        end else if (pop && f_head[DW]) begin
            if (drain_row_q == KEEP_LAST) begin
                phase_q     <= PH_UPPER;
                drain_row_q <= '0;
            end else begin
                drain_row_q <= drain_row_q + 1'b1;
            end
        end
    end

    // Lower-lane holding buffer: {eol, data}.
    seam_fifo #(
        .WIDTH (DW + 1),
        .DEPTH (FIFO_DEPTH)
    ) hold_i (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (d_keep),
        .wdata ({rd_eol, rd_data}),
        .pop   (pop),
        .rdata (f_head),
        .empty (f_empty),
        .full  (f_full)
    );

    // Merged output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_eol   <= 1'b0;
            out_data  <= '0;
        end else if (pop) begin
            out_valid <= 1'b1;
            out_sof   <= 1'b0;
            out_eol   <= f_head[DW];
            out_data  <= f_head[DW-1:0];
        end else begin
            out_valid <= u_keep;
            out_sof   <= u_keep && ru_sos;
            out_eol   <= u_keep && ru_eol;
            if (u_keep) begin
                out_data <= ru_data;
            end
        end
    end

    // R7: upper rows of a new frame never arrive while the lower half is draining.
    p_frame_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_LOWER) |-> !u_keep);

    // R6: draining starts right after the last upper row has been emitted.
    p_drain_after_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phase_q == PH_LOWER) |-> (out_valid && out_eol));

    // R9: the buffer is never full while a kept lower pixel arrives in the upper phase.
    p_hold_room_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (d_keep && (phase_q == PH_UPPER)) |-> !f_full);

endmodule

// File: rtl/frame_seam_split.sv
// Module: frame_seam_split (top)
// Splits a raster frame into two overlapping sections for two parallel 3x3
// pipelines and merges their results back into raster order. Assumes H even and
// at least 8, W >= 2, a power-of-two FIFO_DEPTH, and pipelines that keep the row
// order and markers of their section.
module frame_seam_split #(
    parameter int W          = 8,
    parameter int H          = 16,
    parameter int DW         = 8,
    parameter int SEAM       = 4,
    parameter int FIFO_DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_sof,
    input  logic          in_eol,
    input  logic [DW-1:0] in_data,
    output logic          up_valid,
    output logic          up_sos,
    output logic          up_eol,
    output logic [DW-1:0] up_data,
    output logic          dn_valid,
    output logic          dn_sos,
    output logic          dn_eol,
    output logic [DW-1:0] dn_data,
    input  logic          ru_valid,
    input  logic          ru_sos,
    input  logic          ru_eol,
    input  logic [DW-1:0] ru_data,
    input  logic          rd_valid,
    input  logic          rd_sos,
    input  logic          rd_eol,
    input  logic [DW-1:0] rd_data,
    output logic          out_valid,
    output logic          out_sof,
    output logic          out_eol,
    output logic [DW-1:0] out_data
);

    // Fan-out side.
    seam_splitter #(
        .W    (W),
        .H    (H),
        .DW   (DW),
        .SEAM (SEAM)
    ) split_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sof   (in_sof),
        .in_eol   (in_eol),
        .in_data  (in_data),
        .up_valid (up_valid),
        .up_sos   (up_sos),
        .up_eol   (up_eol),
        .up_data  (up_data),
        .dn_valid (dn_valid),
        .dn_sos   (dn_sos),
        .dn_eol   (dn_eol),
        .dn_data  (dn_data)
    );

    // Fan-in side.
    seam_merger #(
        .W          (W),
        .H          (H),
        .DW         (DW),
        .SEAM       (SEAM),
        .FIFO_DEPTH (FIFO_DEPTH)
    ) merge_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ru_valid  (ru_valid),
        .ru_sos    (ru_sos),
        .ru_eol    (ru_eol),
        .ru_data   (ru_data),
        .rd_valid  (rd_valid),
        .rd_sos    (rd_sos),
        .rd_eol    (rd_eol),
        .rd_data   (rd_data),
        .out_valid (out_valid),
        .out_sof   (out_sof),
        .out_eol   (out_eol),
        .out_data  (out_data)
    );

    // R8: after a reset edge every valid output is low.
    p_reset_quiet_r8: assert property (@(posedge clk)
        $past(!rst_n) |-> !(up_valid || dn_valid || out_valid));

endmodule

// File: tb/frame_seam_split_tb_top.sv
`timescale 1ns/1ps
module frame_seam_split_tb_top;
    localparam int W = 8, H = 16, DW = 8, SEAM = 4, FD = 16;
    localparam int HALF = H / 2;
    localparam int SEC_PIX = (HALF + SEAM) * W;
    localparam int DLY_U = 9, DLY_D = 2;

    // Stimulus vectors: {pattern, gap, seed, expected first merged pixel}.
    localparam int NV = 5;
    localparam logic [19:0] VEC [NV] = '{
        {4'd0, 4'd0, 4'd0, 8'h00},
        {4'd1, 4'd1, 4'd0, 8'hA5},
        {4'd2, 4'd2, 4'd0, 8'h00},
        {4'd3, 4'd0, 4'd3, 8'h4F},
        {4'd3, 4'd3, 4'd5, 8'h79}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 1'b0, in_sof = 1'b0, in_eol = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic up_valid, up_sos, up_eol, dn_valid, dn_sos, dn_eol;
    logic [DW-1:0] up_data, dn_data, out_data;
    logic ru_valid, ru_sos, ru_eol, rd_valid, rd_sos, rd_eol;
    logic [DW-1:0] ru_data, rd_data;
    logic out_valid, out_sof, out_eol;

    always #2.5 clk = ~clk;

    frame_seam_split #(.W(W), .H(H), .DW(DW), .SEAM(SEAM), .FIFO_DEPTH(FD)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_sof(in_sof), .in_eol(in_eol), .in_data(in_data),
        .up_valid(up_valid), .up_sos(up_sos), .up_eol(up_eol), .up_data(up_data),
        .dn_valid(dn_valid), .dn_sos(dn_sos), .dn_eol(dn_eol), .dn_data(dn_data),
        .ru_valid(ru_valid), .ru_sos(ru_sos), .ru_eol(ru_eol), .ru_data(ru_data),
        .rd_valid(rd_valid), .rd_sos(rd_sos), .rd_eol(rd_eol), .rd_data(rd_data),
        .out_valid(out_valid), .out_sof(out_sof), .out_eol(out_eol), .out_data(out_data)
    );

    // Stand-in pipelines: pure delays of unequal length, lower lane faster.
    logic [DW+2:0] dl_u [DLY_U];
    logic [DW+2:0] dl_d [DLY_D];
    always @(posedge clk) begin
        for (int k = 0; k < DLY_U; k++) dl_u[k] <= !rst_n ? '0 : (k == 0 ? {up_valid, up_sos, up_eol, up_data} : dl_u[k-1]);
        for (int k = 0; k < DLY_D; k++) dl_d[k] <= !rst_n ? '0 : (k == 0 ? {dn_valid, dn_sos, dn_eol, dn_data} : dl_d[k-1]);
    end
    assign {ru_valid, ru_sos, ru_eol, ru_data} = dl_u[DLY_U-1];
    assign {rd_valid, rd_sos, rd_eol, rd_data} = dl_d[DLY_D-1];

    int checks = 0, failures = 0;
    bit done = 1'b0;

    // Recorders for lane and merged beats.
    logic [DW+1:0] tq [256];
    logic [DW+1:0] bq [256];
    logic [DW+1:0] oq [256];
    int tn, bn, on, ovl_n, ovl_bad;

    always @(negedge clk) begin
        if (rst_n) begin
            if (up_valid) begin tq[tn & 255] = {up_sos, up_eol, up_data}; tn++; end
            if (dn_valid) begin bq[bn & 255] = {dn_sos, dn_eol, dn_data}; bn++; end
            if (up_valid && dn_valid) begin
                ovl_n++;
                if (up_data != dn_data) ovl_bad++;
            end
            if (out_valid) begin oq[on & 255] = {out_sof, out_eol, out_data}; on++; end
        end
    end

    task automatic clear_rec();
        tn = 0; bn = 0; on = 0; ovl_n = 0; ovl_bad = 0;
    endtask

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pix(input int pat, input int seed, input int r, input int c);
        case (pat)
            0: return DW'(r * W + c);
            1: return 8'hA5;
            2: return ((r ^ c) & 1) != 0 ? 8'hFF : 8'h00;
            default: return DW'(r * 29 + c * 13 + seed * 7) ^ 8'h5A;
        endcase
    endfunction

    // Drive NROWS rows of a frame; GAP junk idle cycles precede every third pixel.
    task automatic send_frame(input int pat, input int gap, input int seed, input int nrows);
        for (int r = 0; r < nrows; r++) begin
            for (int c = 0; c < W; c++) begin
                if ((c % 3) == 0) begin
                    for (int g = 0; g < gap; g++) begin
                        @(negedge clk);
                        in_valid = 1'b0; in_sof = 1'b1; in_eol = 1'b1; in_data = 8'hEE;
                    end
                end
                @(negedge clk);
                in_valid = 1'b1;
                in_sof   = (r == 0 && c == 0);
                in_eol   = (c == W - 1);
                in_data  = pix(pat, seed, r, c);
            end
        end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eol = 1'b0;
    endtask

    task automatic verify(input int pat, input int seed);
        int e_up = 0, e_dn = 0, e_mk = 0, e_out = 0, e_omk = 0;
        for (int i = 0; i < tn && i < 256; i++) begin
            if (tq[i][DW-1:0] != pix(pat, seed, i / W, i % W)) e_up++;
            if (tq[i][DW+1] != (i == 0) || tq[i][DW] != ((i % W) == W - 1)) e_mk++;
        end
        for (int i = 0; i < bn && i < 256; i++) begin
            if (bq[i][DW-1:0] != pix(pat, seed, i / W + HALF - SEAM, i % W)) e_dn++;
            if (bq[i][DW+1] != (i == 0) || bq[i][DW] != ((i % W) == W - 1)) e_mk++;
        end
        for (int i = 0; i < on && i < 256; i++) begin
            if (oq[i][DW-1:0] != pix(pat, seed, i / W, i % W)) e_out++;
            if (oq[i][DW+1] != (i == 0) || oq[i][DW] != ((i % W) == W - 1)) e_omk++;
        end
        chk(tn == SEC_PIX, "R1 upper lane pixel count", tn, SEC_PIX);
        chk(e_up == 0, "R1 upper lane rows 0..H/2+3 content", e_up, 0);
        chk(bn == SEC_PIX, "R2 lower lane pixel count", bn, SEC_PIX);
        chk(e_dn == 0, "R2 lower lane rows H/2-4..H-1 content", e_dn, 0);
        chk(ovl_n == 2 * SEAM * W && ovl_bad == 0, "R3 overlap band on both lanes same cycle", ovl_n * 1000 + ovl_bad, 2 * SEAM * W * 1000);
        chk(e_mk == 0, "R4 lane sos/eol markers", e_mk, 0);
        chk(on == H * W, "R6 merged pixel count", on, H * W);
        chk(e_out == 0, "R7 R9 merged raster content", e_out, 0);
        chk(e_omk == 0, "R7 merged sof/eol markers", e_omk, 0);
    endtask

    task automatic drain();
        repeat (40) @(negedge clk);
    endtask

    // Watchdog.
    initial begin
        #(5.0 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        clear_rec();
        repeat (4) @(negedge clk);
        // R8: reset state.
        chk({up_valid, up_sos, up_eol, dn_valid, dn_sos, dn_eol, out_valid, out_sof, out_eol} == '0,
            "R8 outputs low in reset", int'({up_valid, dn_valid, out_valid}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // Vector walk.
        for (int v = 0; v < NV; v++) begin
            clear_rec();
            send_frame(int'(VEC[v][19:16]), int'(VEC[v][15:12]), int'(VEC[v][11:8]), H);
            drain();
            verify(int'(VEC[v][19:16]), int'(VEC[v][11:8]));
            chk(on > 0 && oq[0][DW-1:0] == VEC[v][7:0], "R7 first merged pixel from table",
                int'(oq[0][DW-1:0]), int'(VEC[v][7:0]));
        end

        // R5: idle cycles with junk markers produce nothing.
        clear_rec();
        for (int g = 0; g < 30; g++) begin
            @(negedge clk);
            in_valid = 1'b0; in_sof = 1'b1; in_eol = 1'b1; in_data = DW'(g);
        end
        @(negedge clk);
        in_sof = 1'b0; in_eol = 1'b0;
        drain();
        chk(tn + bn + on == 0, "R5 invalid cycles ignored", tn + bn + on, 0);
        clear_rec();
        send_frame(2, 1, 0, H);
        drain();
        verify(2, 0);

        // R8: reset in the middle of a frame, then a clean frame.
        clear_rec();
        send_frame(0, 0, 0, 6);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk({up_valid, dn_valid, out_valid} == 3'b000, "R8 outputs low after mid-frame reset",
            int'({up_valid, dn_valid, out_valid}), 0);
        rst_n = 1'b1;
        clear_rec();
        repeat (2) @(negedge clk);
        send_frame(3, 0, 1, H);
        drain();
        verify(3, 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule